// File: doc/BRIEF.md
# ATA PIO cycle timing engine

This block produces a single programmed-I/O read or write on a 16-bit parallel disk bus each time it accepts a request. The caller supplies a request strobe, a direction bit, a 4-bit register address, write data, and three banks of runtime timing counts. The engine then steps through four phases, each counted in system clocks: address setup, strobe active, write hold and end-of-cycle recovery. It drives the two active-low chip selects, the 3-bit device address, the active-low read and write strobes, the data output enable and the write data. It returns the captured read data together with a one-clock acknowledge.

Timing bank 0 serves every access other than the data register. Banks 1 and 2 serve data-register accesses for device 0 and device 1. The device is chosen by the select bit most recently written to the drive/head register. Each bank carries its own enable for IORDY flow control. When that enable is set, a slow device can hold IORDY low to keep the strobe asserted; the engine sees IORDY through a two-flop synchroniser.

Top module: `ata_pio_engine`

## Requirements
- R1: Out of reset both strobes and both chip selects are high, the data output enable is low and the acknowledge is low.
- R2: After the clock edge that accepts a request, the chip select and device address are driven for N1 = max(T1,1) clocks before the strobe asserts, and the address holds steady while the select is active.
- R3: The strobe stays low for N2 = max(T2,1) clocks when flow control is off or IORDY is high. A read pulses only dior_no and a write pulses only diow_no.
- R4: The chip select stays active for N4 = max(T4,1) clocks after the strobe rises and then stays inactive through recovery. ack_o is high for exactly one clock, N1+N2+N4+Ne clocks after the accepting edge, where Ne = max(Teoc,1).
- R5: On a write, dd_oe_o is high from the start of setup to the end of hold and dd_o carries the write data. On a read, dd_oe_o stays low.
- R6: Read data is captured from dd_i on the clock edge at which dior_no rises, and it appears on rdata_o no later than the acknowledge.
- R7: A timing count of zero lasts one clock, so no phase is ever skipped.
- R8: Address 4'h8 is the data register and uses bank 1 plus the device bit. Every other address uses bank 0.
- R9: A write to address 4'hE latches wdata_i bit 4 as the device bit when the write is accepted. The reset value of the device bit is 0.
- R10: When the active bank's IORDY enable is set, the strobe ends only once the count has expired and the synchronised IORDY is high. If IORDY is released at the falling clock edge after the L-th low strobe clock, where L > N2, the strobe lasts L+2 clocks.
- R11: When the active bank's IORDY enable is clear, a low IORDY has no effect on the strobe width.
- R12: A request raised while a cycle is running is ignored. It produces no second cycle and no second acknowledge.
- R13: Address bit 3 set drives cs0_no low. Address bit 3 clear drives cs1_no low. da_o equals address bits 2:0 while a select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address: bit 3 picks the select, bits 2:0 drive DA |
| wdata_i | input | 16 | Write data |
| t1_i | input | 3x8 | Address setup count per bank |
| t2_i | input | 3x8 | Strobe active count per bank |
| t4_i | input | 3x8 | Write hold count per bank |
| teoc_i | input | 3x8 | Recovery count per bank |
| iordy_en_i | input | 3 | IORDY flow-control enable per bank |
| iordy_i | input | 1 | Device ready, asynchronous |
| dd_i | input | 16 | Device data bus in |
| dd_o | output | 16 | Device data bus out |
| dd_oe_o | output | 1 | Data bus output enable |
| da_o | output | 3 | Device address |
| cs0_no | output | 1 | Command block select, active low |
| cs1_no | output | 1 | Control block select, active low |
| dior_no | output | 1 | Read strobe, active low |
| diow_no | output | 1 | Write strobe, active low |
| rdata_o | output | 16 | Captured read data |
| ack_o | output | 1 | One-clock completion pulse |

## Verification
Every output follows from the registered phase state. The strobe therefore first shows low N1 clocks after the accepting edge, and the acknowledge shows N1+N2+N4+Ne clocks after it. The bench drives inputs on falling edges and samples once per falling edge, numbering the samples from the accepting edge. It then compares the index of the first low strobe, the length of each low or high run, and the index of the acknowledge against these sums. Read data is changed on every strobe clock, so only the value present just before the releasing edge can match. IORDY releases are timed so that the two synchroniser stages add exactly two clocks.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int DA_W        = 3;
  localparam int ADDR_W      = 4;
  localparam logic [ADDR_W-1:0] DATA_REG_ADDR = 4'h8;
  localparam logic [ADDR_W-1:0] DRVHEAD_ADDR  = 4'hE;
  localparam int DEV_SEL_BIT = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RECOV
  } phase_e;
endpackage

// File: rtl/ata_iordy_sync.sv
module ata_iordy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], async_i};
  end

  assign sync_o = sr_q[STAGES-1];
endmodule

// File: rtl/ata_tset_sel.sv
module ata_tset_sel
  import ata_pio_pkg::*;
#(
  parameter int NSETS  = 3,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        accept_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NSETS-1:0][CNT_W-1:0] t1_i,
  input  logic [NSETS-1:0][CNT_W-1:0] t2_i,
  input  logic [NSETS-1:0][CNT_W-1:0] t4_i,
  input  logic [NSETS-1:0][CNT_W-1:0] teoc_i,
  input  logic [NSETS-1:0]            iordy_en_i,
  output logic [CNT_W-1:0]            n1_o,
  output logic [CNT_W-1:0]            n2_o,
  output logic [CNT_W-1:0]            n4_o,
  output logic [CNT_W-1:0]            ne_o,
  output logic                        iordy_en_o
);
  localparam int SEL_W = (NSETS > 1) ? $clog2(NSETS) : 1;

  logic [NSETS-1:0][CNT_W-1:0] c1, c2, c4, ce;
  logic                        dev_q;
  logic [SEL_W-1:0]            idx;

  // zero counts are stretched to one clock
  for (genvar g = 0; g < NSETS; g++) begin : g_clamp
    assign c1[g] = (t1_i[g]   == '0) ? CNT_W'(1) : t1_i[g];
    assign c2[g] = (t2_i[g]   == '0) ? CNT_W'(1) : t2_i[g];
    assign c4[g] = (t4_i[g]   == '0) ? CNT_W'(1) : t4_i[g];
    assign ce[g] = (teoc_i[g] == '0) ? CNT_W'(1) : teoc_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dev_q <= 1'b0;
    else if (accept_i && we_i && addr_i == DRVHEAD_ADDR) dev_q <= wdata_i[DEV_SEL_BIT];
  end

  always_comb begin
    if (addr_i == DATA_REG_ADDR) idx = SEL_W'(1) + SEL_W'(dev_q);
    else                         idx = '0;
  end

  assign n1_o       = c1[idx];
  assign n2_o       = c2[idx];
  assign n4_o       = c4[idx];
  assign ne_o       = ce[idx];
  assign iordy_en_o = iordy_en_i[idx];
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  n1_i,
  input  logic [CNT_W-1:0]  n2_i,
  input  logic [CNT_W-1:0]  n4_i,
  input  logic [CNT_W-1:0]  ne_i,
  input  logic              iordy_en_i,
  input  logic              iordy_s_i,
  input  logic [DATA_W-1:0] dd_i,
  output logic              accept_o,
  output logic [DATA_W-1:0] dd_o,
  output logic              dd_oe_o,
  output logic [DA_W-1:0]   da_o,
  output logic              cs0_no,
  output logic              cs1_no,
  output logic              dior_no,
  output logic              diow_no,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o
);
  phase_e              state_q;
  logic [CNT_W-1:0]    cnt_q, n2_q, n4_q, ne_q;
  logic                we_q, ien_q, ack_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q;
  logic                cnt_done, active;

  assign accept_o = req_i && (state_q == PH_IDLE);
  assign cnt_done = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      n2_q    <= '0;
      n4_q    <= '0;
      ne_q    <= '0;
      we_q    <= 1'b0;
      ien_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (state_q)
        PH_IDLE: if (accept_o) begin
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          n2_q    <= n2_i;
          n4_q    <= n4_i;
          ne_q    <= ne_i;
          ien_q   <= iordy_en_i;
          cnt_q   <= n1_i - CNT_W'(1);
          state_q <= PH_SETUP;
        end
        PH_SETUP: if (cnt_done) begin
          cnt_q   <= n2_q - CNT_W'(1);
          state_q <= PH_STROBE;
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_STROBE: if (!cnt_done) cnt_q <= cnt_q - CNT_W'(1);
        else if (!ien_q || iordy_s_i) begin
          if (!we_q) rdata_q <= dd_i;
          cnt_q   <= n4_q - CNT_W'(1);
          state_q <= PH_HOLD;
        end
        PH_HOLD: if (cnt_done) begin
          cnt_q   <= ne_q - CNT_W'(1);
          state_q <= PH_RECOV;
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_RECOV: if (cnt_done) begin
          ack_q   <= 1'b1;
          state_q <= PH_IDLE;
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign active  = (state_q == PH_SETUP) || (state_q == PH_STROBE) || (state_q == PH_HOLD);
  assign cs0_no  = !(active && addr_q[3]);
  assign cs1_no  = !(active && !addr_q[3]);
  assign da_o    = active ? addr_q[DA_W-1:0] : '0;
  assign dior_no = !(state_q == PH_STROBE && !we_q);
  assign diow_no = !(state_q == PH_STROBE && we_q);
  assign dd_oe_o = active && we_q;
  assign dd_o    = wdata_q;
  assign rdata_o = rdata_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int NSETS  = 3,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NSETS-1:0][CNT_W-1:0] t1_i,
  input  logic [NSETS-1:0][CNT_W-1:0] t2_i,
  input  logic [NSETS-1:0][CNT_W-1:0] t4_i,
  input  logic [NSETS-1:0][CNT_W-1:0] teoc_i,
  input  logic [NSETS-1:0]            iordy_en_i,
  input  logic                        iordy_i,
  input  logic [DATA_W-1:0]           dd_i,
  output logic [DATA_W-1:0]           dd_o,
  output logic                        dd_oe_o,
  output logic [DA_W-1:0]             da_o,
  output logic                        cs0_no,
  output logic                        cs1_no,
  output logic                        dior_no,
  output logic                        diow_no,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        ack_o
);
  logic [CNT_W-1:0] n1, n2, n4, ne;
  logic             ien, iordy_s, accept;

  ata_iordy_sync #(.STAGES(2)) i_sync (
    .clk_i, .rst_ni, .async_i(iordy_i), .sync_o(iordy_s)
  );

  ata_tset_sel #(.NSETS(NSETS), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_sel (
    .clk_i, .rst_ni, .accept_i(accept), .we_i, .addr_i, .wdata_i,
    .t1_i, .t2_i, .t4_i, .teoc_i, .iordy_en_i,
    .n1_o(n1), .n2_o(n2), .n4_o(n4), .ne_o(ne), .iordy_en_o(ien)
  );

  ata_pio_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .n1_i(n1), .n2_i(n2), .n4_i(n4), .ne_i(ne),
    .iordy_en_i(ien), .iordy_s_i(iordy_s), .dd_i,
    .accept_o(accept), .dd_o, .dd_oe_o, .da_o, .cs0_no, .cs1_no,
    .dior_no, .diow_no, .rdata_o, .ack_o
  );
endmodule

// File: rtl/ata_pio_checker.sv
module ata_pio_checker
  import ata_pio_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [DA_W-1:0] da_o,
  input logic            cs0_no,
  input logic            cs1_no,
  input logic            dior_no,
  input logic            diow_no,
  input logic            dd_oe_o,
  input logic            ack_o
);
  p_one_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dior_no && !diow_no));

  p_strobe_one_cs_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dior_no || !diow_no) |-> (cs0_no ^ cs1_no));

  p_no_oe_on_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dior_no |-> !dd_oe_o);

  p_ack_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  p_ack_bus_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (cs0_no && cs1_no && dior_no && diow_no && !dd_oe_o));

  p_da_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs0_no || !cs1_no) |=> ((cs0_no && cs1_no) || $stable(da_o)));
endmodule

bind ata_pio_engine ata_pio_checker i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .da_o(da_o), .cs0_no(cs0_no),
  .cs1_no(cs1_no), .dior_no(dior_no), .diow_no(diow_no),
  .dd_oe_o(dd_oe_o), .ack_o(ack_o)
);

// File: tb/test_ata_pio_engine.sv
module test_ata_pio_engine;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_i = 1'b0, we_i = 1'b0;
  logic [3:0]       addr_i = '0;
  logic [15:0]      wdata_i = '0, dd_i = '0;
  logic [2:0][7:0]  t1_i, t2_i, t4_i, teoc_i;
  logic [2:0]       iordy_en_i = '0;
  logic             iordy_i = 1'b1;
  logic [15:0]      dd_o, rdata_o;
  logic             dd_oe_o, cs0_no, cs1_no, dior_no, diow_no, ack_o;
  logic [2:0]       da_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  ata_pio_engine i_ata_pio_engine (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // one transaction; e1,e4,ee are clamped counts, es the expected strobe width
  task automatic run(input bit we, input logic [3:0] a, input logic [15:0] wd,
                     input int e1, input int es, input int e4, input int ee,
                     input int rel_at, input bit poke, input string ctx);
    int c = 0, sc = 0, fst = 0, csc = 0, oec = 0, ackc = 0, ackn = 0, bad = 0;
    logic [15:0] base = 16'h3C00 ^ wd;
    logic [15:0] rd_got = '0;
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = wd; dd_i = base;
    if (rel_at > 0) iordy_i = 1'b0;
    while (c < 400 && (ackc == 0 || c < ackc + 3)) begin
      @(negedge clk_i);
      c++;
      req_i = (poke && c == 2);
      if (!(we ? diow_no : dior_no)) begin
        sc++;
        if (fst == 0) fst = c;
        if (rel_at > 0 && sc == rel_at) iordy_i = 1'b1;
      end
      if (!(we ? dior_no : diow_no)) bad++;
      if (!we) dd_i = base + 16'(sc);
      if (!cs0_no || !cs1_no) begin
        csc++;
        if (cs0_no != !a[3] || cs1_no != a[3] || da_o != a[2:0]) bad++;
      end
      if (dd_oe_o) begin
        oec++;
        if (dd_o != wd) bad++;
      end
      if (ack_o) begin
        ackn++;
        if (ackc == 0) begin ackc = c; rd_got = rdata_o; end
      end
    end
    chk(fst == e1 + 1, {"R2 setup ", ctx}, fst, e1 + 1);
    chk(sc == es, {"R3/R10/R11 strobe width ", ctx}, sc, es);
    chk(csc == e1 + es + e4, {"R4 select span ", ctx}, csc, e1 + es + e4);
    chk(oec == (we ? e1 + es + e4 : 0), {"R5 output enable ", ctx}, oec, we ? e1 + es + e4 : 0);
    chk(ackc == e1 + es + e4 + ee + 1, {"R4 ack cycle ", ctx}, ackc, e1 + es + e4 + ee + 1);
    chk(ackn == 1, {"R12 ack count ", ctx}, ackn, 1);
    chk(bad == 0, {"R13 select/address/strobe/data ", ctx}, bad, 0);
    if (!we) chk(rd_got == base + 16'(es), {"R6 read capture ", ctx}, int'(rd_got), int'(base + 16'(es)));
    iordy_i = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    t1_i = '0; t2_i = '0; t4_i = '0; teoc_i = '0;
    t1_i[1] = 8'd2; t2_i[1] = 8'd3; t4_i[1] = 8'd1; teoc_i[1] = 8'd2;
    t1_i[2] = 8'd4; t2_i[2] = 8'd5; t4_i[2] = 8'd2; teoc_i[2] = 8'd1;
    t1_i[0] = 8'd1; t2_i[0] = 8'd2; t4_i[0] = 8'd1; teoc_i[0] = 8'd1;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(dior_no && diow_no, "R1 strobes high in reset", int'({dior_no, diow_no}), 3);
    chk(cs0_no && cs1_no, "R1 selects high in reset", int'({cs0_no, cs1_no}), 3);
    chk(!dd_oe_o && !ack_o, "R1 oe/ack low in reset", int'({dd_oe_o, ack_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(dior_no && diow_no && cs0_no && cs1_no && !dd_oe_o && !ack_o,
        "R1 idle after reset", 0, 0);

    // R8 data read after reset uses bank 1 (device bit 0)
    run(0, 4'h8, 16'h0000, 2, 3, 1, 2, 0, 0, "R8 dev0 read");
    // R9 select device 1, then data write uses bank 2
    run(1, 4'hE, 16'h0010, 1, 2, 1, 1, 0, 0, "R9 drvhead dev1");
    run(1, 4'h8, 16'hBEEF, 4, 5, 2, 1, 0, 0, "R9 R8 dev1 write");
    // non-data access stays on bank 0 while device 1 selected
    run(0, 4'hF, 16'h0000, 1, 2, 1, 1, 0, 0, "R8 status uses bank0");
    run(1, 4'hE, 16'h0000, 1, 2, 1, 1, 0, 0, "R9 drvhead dev0");
    run(0, 4'h8, 16'h1234, 2, 3, 1, 2, 0, 0, "R9 back to bank1");
    // R13 control block select
    run(0, 4'h6, 16'h0042, 1, 2, 1, 1, 0, 0, "R13 cs1 read");
    run(1, 4'h6, 16'h0042, 1, 2, 1, 1, 0, 0, "R13 cs1 write");
    // R10 stretch: enabled, released after 5 low clocks -> 7
    iordy_en_i = 3'b001;
    run(0, 4'h7, 16'h0100, 1, 7, 1, 1, 5, 0, "R10 stretch read");
    run(1, 4'h7, 16'h0200, 1, 7, 1, 1, 5, 0, "R10 stretch write");
    // R11 disabled: low IORDY ignored
    iordy_en_i = 3'b000;
    run(0, 4'h7, 16'h0300, 1, 2, 1, 1, 5, 0, "R11 iordy ignored");
    // R12 request during busy
    run(1, 4'h9, 16'h0400, 1, 2, 1, 1, 0, 1, "R12 busy request");

    // R7 sweep of bank 0 counts including zero, flow control on with IORDY high
    iordy_en_i = 3'b001;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int d = 0; d < 3; d++)
          for (int e = 0; e < 3; e++) begin
            t1_i[0] = 8'(a); t2_i[0] = 8'(b); t4_i[0] = 8'(d); teoc_i[0] = 8'(e);
            run(((a + b + d + e) % 2) == 1, 4'hA, 16'(a * 64 + b * 16 + d * 4 + e),
                (a == 0) ? 1 : a, (b == 0) ? 1 : b, (d == 0) ? 1 : d, (e == 0) ? 1 : e,
                0, 0, "R7 sweep");
          end
    done = 1;
  end

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk_i);
      cycles++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule